// File: doc/BRIEF.md
# PWM Duty Dimming Decoder

This block turns a brightness PWM signal into drive controls for a bank of LED current sinks. It samples the PWM input on a fast clock and synchronises it. It then removes short glitches and measures the high time and the period between consecutive rising edges. From those two counts it computes a 10-bit duty code. The fewer clocks a period holds, the fewer low-order bits of that code are kept, so resolution falls as the input frequency rises.

A 2-bit mode input selects one of three forms of output:

- **Direct:** the channel gates copy the filtered input, and the amplitude stays at full scale.
- **Mixed:** the duty becomes a DC amplitude at or above one quarter of full scale. Below a quarter, the amplitude is held at a quarter and the sinks are gated on and off once per input period, so the average current still follows the input.
- **Analog:** the duty becomes an amplitude only, clamped at a small floor. No gating is applied.

When no rising edge arrives for a long time, the input is treated as a DC level. The outputs are plain levels held in registers: a 10-bit amplitude code, one gate bit per channel and a valid flag. They update whenever a new measurement completes. Each output holds its value until the next measurement replaces it, so there is no back-pressure and no ready signal.

Top module: `dim_duty_decoder`

## Requirements
- R1: While and after reset, before any measurement: `amp_o` = 0, `gate_o` = 0, `valid_o` = 0.
- R2: `mode_i` = 00 (direct): `valid_o` = 1 and `amp_o` = 1023. Every bit of `gate_o` equals the input level after the filter, changing exactly GLITCH_CYC+3 clocks after the input changes.
- R3: An input level that lasts fewer than GLITCH_CYC clocks has no effect on the outputs. A level that lasts GLITCH_CYC clocks or longer passes through with its length unchanged.
- R4: The duty code is floor(1024·H/P), where H is the count of high clocks and P the count of period clocks between two rising edges. When P ≥ FINE_MIN_CYC, all 10 bits are kept. When MID_MIN_CYC ≤ P < FINE_MIN_CYC, bit 0 is cleared. When P < MID_MIN_CYC, bits 1:0 are cleared.
- R5: `mode_i` = 01 (mixed) with a code ≥ 256: `amp_o` = code and `gate_o` = all ones.
- R6: `mode_i` = 01 with a code < 256: `amp_o` = 256. After each rising edge the gates are on for 4·H clocks, then off until the next rising edge.
- R7: `mode_i` = 10 (analog): `amp_o` = max(code, AMP_FLOOR) and `gate_o` = all ones. `mode_i` = 11 behaves the same as 10.
- R8: In mixed and analog modes, `valid_o` rises only after two complete periods have been measured and at least MIN_CYC clocks have passed since reset. While `valid_o` = 0, `amp_o` and `gate_o` are 0.
- R9: If no rising edge arrives for DC_CYC clocks, the input is treated as DC. A low level gives `amp_o` = 0 and gates off. A high level gives `amp_o` = 1023 and gates on. Either case sets `valid_o` = 1.
- R10: All bits of `gate_o` are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | Brightness PWM input, asynchronous |
| mode_i | input | 2 | Dimming mode: 00 direct, 01 mixed, 10 or 11 analog |
| amp_o | output | CODE_W | Amplitude code for all sinks, full scale = all ones |
| gate_o | output | CH | On/off gate, one bit per channel |
| valid_o | output | 1 | Amplitude and gate carry a decoded value |

## Verification
The bench targets the following corner cases:

- **Duty of exactly 25% in mixed mode.** This must stay in the amplitude region. A design with an off-by-one threshold would switch to gated output at amplitude 256.
- **Period lengths on each side of the two range limits.** A design that truncates against the wrong limit reports a code that is off by one or three.
- **Gated output below 25%.** The bench counts the total gate-on time across whole input periods. A design that does not multiply the high time by four dims too far.
- **Pulses one clock shorter than the filter length, and exactly equal to it.** A design with an off-by-one in the filter either lets glitches through or stretches or drops real pulses.
- **Direct-mode latency, measured to the exact cycle.**
- **Valid withheld after only one measured period.**
- **Floor clamp in analog mode.**
- **Stuck-low and stuck-high inputs.** A design without the timeout would hold a stale code indefinitely.

// File: rtl/dim_pkg.sv
`timescale 1ns/1ps
package dim_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT     = 2'b00,
    MODE_MIXED      = 2'b01,
    MODE_ANALOG     = 2'b10,
    MODE_ANALOG_ALT = 2'b11
  } dim_mode_e;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_LOW  = 2'b01,
    LVL_HIGH = 2'b10
  } dc_state_e;

endpackage

// File: rtl/dim_input_filter.sv
`timescale 1ns/1ps
// Two-flop synchroniser followed by a run-length deglitch filter.
module dim_input_filter #(
  parameter int GLITCH_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pwm_i,
  output logic level_o,
  output logic rise_o
);
  localparam int GW = $clog2(GLITCH_CYC + 1);

  logic [1:0]    sync_q;
  logic [GW-1:0] run_q;
  logic          level_q;
  logic          level_d1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      run_q      <= '0;
      level_q    <= 1'b0;
      level_d1_q <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], pwm_i};
      level_d1_q <= level_q;
      if (sync_q[1] == level_q) begin
        run_q <= '0;
      end else if (run_q == GW'(GLITCH_CYC - 1)) begin
        level_q <= sync_q[1];
        run_q   <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign level_o = level_q;
  assign rise_o  = level_q & ~level_d1_q;
endmodule

// File: rtl/dim_period_meter.sv
`timescale 1ns/1ps
// Counts period and high time between rising edges; flags a DC input on timeout.
module dim_period_meter #(
  parameter int DC_CYC = 500000,
  parameter int CW     = 19
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          level_i,
  input  logic          rise_i,
  output logic          samp_o,
  output logic [CW-1:0] per_o,
  output logic [CW-1:0] hi_o,
  output logic          dc_o,
  output logic          dc_level_o
);
  logic [CW-1:0] per_q;
  logic [CW-1:0] hi_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q      <= '0;
      hi_q       <= '0;
      armed_q    <= 1'b0;
      samp_o     <= 1'b0;
      per_o      <= '0;
      hi_o       <= '0;
      dc_o       <= 1'b0;
      dc_level_o <= 1'b0;
    end else begin
      samp_o <= 1'b0;
      dc_o   <= 1'b0;
      if (rise_i) begin
        if (armed_q) begin
          samp_o <= 1'b1;
          per_o  <= per_q;
          hi_o   <= hi_q;
        end
        armed_q <= 1'b1;
        per_q   <= CW'(1);
        hi_q    <= CW'(1);
      end else if (per_q == CW'(DC_CYC - 1)) begin
        dc_o       <= 1'b1;
        dc_level_o <= level_i;
        armed_q    <= 1'b0;
        per_q      <= CW'(DC_CYC);
      end else if (per_q < CW'(DC_CYC)) begin
        per_q <= per_q + 1'b1;
        hi_q  <= hi_q + CW'(level_i);
      end
    end
  end
endmodule

// File: rtl/dim_ratio_div.sv
`timescale 1ns/1ps
// Bit-serial restoring divider: quo = floor(num * 2^QW / den), requires num < den.
module dim_ratio_div #(
  parameter int CW = 19,
  parameter int QW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [CW-1:0] num_i,
  input  logic [CW-1:0] den_i,
  output logic          done_o,
  output logic [QW-1:0] quo_o,
  output logic [CW-1:0] den_o
);
  localparam int SW = $clog2(QW + 1);

  logic [CW:0]   rem_q;
  logic [SW-1:0] step_q;
  logic          busy_q;
  logic [CW:0]   shl;
  logic          fits;

  assign shl  = {rem_q[CW-1:0], 1'b0};
  assign fits = shl >= {1'b0, den_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      quo_o  <= '0;
      den_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q <= 1'b1;
          rem_q  <= {1'b0, num_i};
          den_o  <= den_i;
          quo_o  <= '0;
          step_q <= SW'(QW);
        end
      end else begin
        rem_q  <= fits ? (shl - {1'b0, den_o}) : shl;
        quo_o  <= {quo_o[QW-2:0], fits};
        step_q <= step_q - 1'b1;
        if (step_q == SW'(1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dim_level_map.sv
`timescale 1ns/1ps
// Maps mode, decoded duty and DC state to amplitude and gate level.
module dim_level_map
  import dim_pkg::*;
#(
  parameter int QW        = 10,
  parameter int AMP_FLOOR = 10
) (
  input  dim_mode_e     mode_i,
  input  logic          have_i,
  input  dc_state_e     dc_i,
  input  logic [QW-1:0] duty_i,
  input  logic          regen_i,
  input  logic          level_i,
  output logic [QW-1:0] amp_o,
  output logic          on_o
);
  localparam logic [QW-1:0] FULL    = '1;
  localparam logic [QW-1:0] QUARTER = QW'(1) << (QW - 2);
  localparam logic [QW-1:0] FLOOR   = QW'(AMP_FLOOR);

  always_comb begin
    amp_o = '0;
    on_o  = 1'b0;
    if (mode_i == MODE_DIRECT) begin
      amp_o = FULL;
      on_o  = level_i;
    end else if (!have_i) begin
      amp_o = '0;
      on_o  = 1'b0;
    end else if (dc_i == LVL_LOW) begin
      amp_o = '0;
      on_o  = 1'b0;
    end else if (dc_i == LVL_HIGH) begin
      amp_o = FULL;
      on_o  = 1'b1;
    end else if (mode_i == MODE_MIXED) begin
      if (duty_i >= QUARTER) begin
        amp_o = duty_i;
        on_o  = 1'b1;
      end else begin
        amp_o = QUARTER;
        on_o  = regen_i;
      end
    end else begin
      amp_o = (duty_i < FLOOR) ? FLOOR : duty_i;
      on_o  = 1'b1;
    end
  end
endmodule

// File: rtl/dim_duty_decoder.sv
`timescale 1ns/1ps
module dim_duty_decoder
  import dim_pkg::*;
#(
  parameter int CH           = 6,
  parameter int CODE_W       = 10,
  parameter int GLITCH_CYC   = 3,
  parameter int DC_CYC       = 500000,
  parameter int MIN_CYC      = 10000,
  parameter int FINE_MIN_CYC = 5000,
  parameter int MID_MIN_CYC  = 2500,
  parameter int AMP_FLOOR    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pwm_i,
  input  logic [1:0]        mode_i,
  output logic [CODE_W-1:0] amp_o,
  output logic [CH-1:0]     gate_o,
  output logic              valid_o
);
  localparam int CW = $clog2(DC_CYC + 1);
  localparam int RW = CW + 2;
  localparam int SW = $clog2(MIN_CYC + 1);

  logic level, rise;
  logic samp, dc_evt, dc_lvl;
  logic [CW-1:0] samp_per, samp_hi;
  logic div_done;
  logic [CODE_W-1:0] div_quo;
  logic [CW-1:0] div_den;

  dim_input_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filter (
    .clk_i(clk_i), .rst_ni(rst_ni), .pwm_i(pwm_i),
    .level_o(level), .rise_o(rise)
  );

  dim_period_meter #(.DC_CYC(DC_CYC), .CW(CW)) u_meter (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_i(level), .rise_i(rise),
    .samp_o(samp), .per_o(samp_per), .hi_o(samp_hi),
    .dc_o(dc_evt), .dc_level_o(dc_lvl)
  );

  dim_ratio_div #(.CW(CW), .QW(CODE_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(samp),
    .num_i(samp_hi), .den_i(samp_per),
    .done_o(div_done), .quo_o(div_quo), .den_o(div_den)
  );

  // Resolution follows the measured period length.
  logic [CODE_W-1:0] quant;
  always_comb begin
    quant = div_quo;
    if (div_den < CW'(MID_MIN_CYC)) begin
      quant[1:0] = 2'b00;
    end else if (div_den < CW'(FINE_MIN_CYC)) begin
      quant[0] = 1'b0;
    end
  end

  logic [CODE_W-1:0] duty_q;
  dc_state_e         dc_q;
  logic [1:0]        nres_q;
  logic              dc_seen_q;
  logic [SW-1:0]     settle_q;
  logic [RW-1:0]     on_len_q;
  logic [RW-1:0]     regen_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q      <= '0;
      dc_q        <= LVL_NONE;
      nres_q      <= '0;
      dc_seen_q   <= 1'b0;
      settle_q    <= '0;
      on_len_q    <= '0;
      regen_cnt_q <= '1;
    end else begin
      if (div_done) begin
        duty_q <= quant;
        dc_q   <= LVL_NONE;
        if (nres_q != 2'd2) nres_q <= nres_q + 1'b1;
      end else if (dc_evt) begin
        dc_q      <= dc_lvl ? LVL_HIGH : LVL_LOW;
        dc_seen_q <= 1'b1;
      end
      if (samp) on_len_q <= {samp_hi, 2'b00};
      if (rise) regen_cnt_q <= '0;
      else if (regen_cnt_q != '1) regen_cnt_q <= regen_cnt_q + 1'b1;
      if (settle_q != SW'(MIN_CYC)) settle_q <= settle_q + 1'b1;
    end
  end

  logic have, regen, map_on;
  logic [CODE_W-1:0] map_amp;
  dim_mode_e mode_e;

  assign have   = ((nres_q == 2'd2) || dc_seen_q) && (settle_q == SW'(MIN_CYC));
  assign regen  = regen_cnt_q < on_len_q;
  assign mode_e = dim_mode_e'(mode_i);

  dim_level_map #(.QW(CODE_W), .AMP_FLOOR(AMP_FLOOR)) u_map (
    .mode_i(mode_e), .have_i(have), .dc_i(dc_q), .duty_i(duty_q),
    .regen_i(regen), .level_i(level), .amp_o(map_amp), .on_o(map_on)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      amp_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      amp_o   <= map_amp;
      valid_o <= (mode_e == MODE_DIRECT) || have;
    end
  end

  for (genvar c = 0; c < CH; c++) begin : g_chan
    logic en_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) en_q <= 1'b0;
      else         en_q <= map_on;
    end
    assign gate_o[c] = en_q;
  end
endmodule

// File: rtl/dim_duty_decoder_chk.sv
`timescale 1ns/1ps
module dim_duty_decoder_chk #(
  parameter int CH        = 6,
  parameter int CODE_W    = 10,
  parameter int AMP_FLOOR = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_i,
  input logic [CODE_W-1:0] amp_o,
  input logic [CH-1:0]     gate_o,
  input logic              valid_o
);
  localparam logic [CODE_W-1:0] FULL    = '1;
  localparam logic [CODE_W-1:0] QUARTER = CODE_W'(1) << (CODE_W - 2);

  assert_gate_uniform_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_o == '0) || (gate_o == '1));

  assert_direct_full_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00) |=> (valid_o && amp_o == FULL));

  assert_invalid_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (amp_o == '0 && gate_o == '0));

  assert_mixed_quarter_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01) |=> (!valid_o || amp_o == '0 || amp_o >= QUARTER));

  assert_analog_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |=> ((amp_o == '0) == (gate_o == '0)));

  assert_analog_floor_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i[1] |=> (amp_o == '0 || amp_o >= CODE_W'(AMP_FLOOR)));
endmodule

bind dim_duty_decoder dim_duty_decoder_chk #(
  .CH(CH), .CODE_W(CODE_W), .AMP_FLOOR(AMP_FLOOR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_i),
  .amp_o(amp_o), .gate_o(gate_o), .valid_o(valid_o)
);

// File: tb/sim_dim_duty_decoder.sv
`timescale 1ns/1ps
module sim_dim_duty_decoder;
  localparam int G     = 3;
  localparam int DCC   = 3000;
  localparam int MINC  = 400;
  localparam int FINE  = 1200;
  localparam int MID   = 600;
  localparam int FLOOR = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm = 1'b0;
  logic [1:0] mode = 2'b01;
  logic [9:0] amp;
  logic [5:0] gate;
  logic vld;

  always #2.5 clk = ~clk;

  dim_duty_decoder #(
    .CH(6), .CODE_W(10), .GLITCH_CYC(G), .DC_CYC(DCC), .MIN_CYC(MINC),
    .FINE_MIN_CYC(FINE), .MID_MIN_CYC(MID), .AMP_FLOOR(FLOOR)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwm_i(pwm), .mode_i(mode),
    .amp_o(amp), .gate_o(gate), .valid_o(vld)
  );

  typedef struct {
    int         cyc;
    logic [9:0] amp;
    logic [5:0] gate;
    logic       vld;
    logic       chk_amp;
    logic       chk_gate;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  logic cnt_en = 1'b0;
  int gcount = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cnt_en && gate[0]) gcount <= gcount + 1;
  end

  // Monitor: pops expectations as their cycle comes up and compares.
  always @(negedge clk) begin
    exp_t e;
    while (sb.size() != 0 && sb[0].cyc <= cyc) begin
      e = sb.pop_front();
      n_chk++;
      if (e.cyc != cyc ||
          (e.chk_amp && amp != e.amp) ||
          (e.chk_gate && gate != e.gate) ||
          vld != e.vld) begin
        n_fail++;
        $display("FAIL %s cyc=%0d: amp=%0d exp %0d, gate=%h exp %h, valid=%0b exp %0b",
                 e.tag, cyc, amp, e.amp, gate, e.gate, vld, e.vld);
      end
    end
  end

  task automatic expect_at(input int dly, input logic [9:0] a, input logic [5:0] g,
                           input logic v, input logic ca, input logic cg, input string tag);
    exp_t e;
    e.cyc = cyc + dly; e.amp = a; e.gate = g; e.vld = v;
    e.chk_amp = ca; e.chk_gate = cg; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic check_val(input string tag, input int act, input int expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int exp_code(input int h, input int p);
    int q;
    q = (h * 1024) / p;
    if (p < MID) q = q & ~3;
    else if (p < FINE) q = q & ~1;
    return q;
  endfunction

  task automatic run_pwm(input int h, input int p, input int n);
    for (int k = 0; k < n; k++) begin
      pwm = 1'b1;
      repeat (h) @(negedge clk);
      pwm = 1'b0;
      repeat (p - h) @(negedge clk);
    end
  endtask

  task automatic pattern(input int h, input int p, input int a, input logic cg, input string tag);
    expect_at(2 * p + p / 2, 10'(a), 6'h3f, 1'b1, 1'b1, cg, tag);
    run_pwm(h, p, 3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: quiet after reset
    expect_at(1, 10'd0, 6'h00, 1'b0, 1'b1, 1'b1, "R1 reset state");
    @(negedge clk);

    // R8 valid withheld after one period; R5/R4 amplitude after two
    expect_at(1200 + 600, 10'd0, 6'h00, 1'b0, 1'b1, 1'b1, "R8 one period only");
    pattern(600, 1200, exp_code(600, 1200), 1'b1, "R5 R4 half duty");
    // R5 boundary: exactly 25 percent stays in amplitude region
    pattern(300, 1200, exp_code(300, 1200), 1'b1, "R5 quarter boundary");
    // R6 gated region
    pattern(150, 1200, 256, 1'b0, "R6 amplitude at quarter");
    gcount = 0;
    cnt_en = 1'b1;
    run_pwm(150, 1200, 2);
    cnt_en = 1'b0;
    check_val("R6 gate on-time over two periods", gcount, 2 * 4 * 150);
    // R4 mid and coarse ranges
    pattern(301, 800, exp_code(301, 800), 1'b1, "R4 mid range drops bit0");
    pattern(201, 400, exp_code(201, 400), 1'b1, "R4 coarse range drops bits1:0");

    // R7 analog
    mode = 2'b10;
    pattern(6, 1200, FLOOR, 1'b1, "R7 analog floor");
    pattern(900, 1200, exp_code(900, 1200), 1'b1, "R7 analog high duty");
    mode = 2'b11;
    pattern(150, 1200, exp_code(150, 1200), 1'b1, "R7 mode 11 as analog");

    // R9 DC levels
    mode = 2'b01;
    pwm = 1'b0;
    expect_at(DCC + 100, 10'd0, 6'h00, 1'b1, 1'b1, 1'b1, "R9 stuck low");
    repeat (DCC + 200) @(negedge clk);
    pwm = 1'b1;
    expect_at(DCC + 100, 10'd1023, 6'h3f, 1'b1, 1'b1, 1'b1, "R9 stuck high");
    repeat (DCC + 200) @(negedge clk);

    // R2 direct mode and exact latency
    mode = 2'b00;
    pwm = 1'b0;
    repeat (20) @(negedge clk);
    expect_at(1, 10'd1023, 6'h00, 1'b1, 1'b1, 1'b1, "R2 direct idle");
    @(negedge clk);
    pwm = 1'b1;
    expect_at(G + 2, 10'd1023, 6'h00, 1'b1, 1'b1, 1'b1, "R2 rise not yet");
    expect_at(G + 3, 10'd1023, 6'h3f, 1'b1, 1'b1, 1'b1, "R2 rise latency");
    repeat (20) @(negedge clk);
    pwm = 1'b0;
    expect_at(G + 2, 10'd1023, 6'h3f, 1'b1, 1'b1, 1'b1, "R2 fall not yet");
    expect_at(G + 3, 10'd1023, 6'h00, 1'b1, 1'b1, 1'b1, "R2 fall latency");
    repeat (20) @(negedge clk);

    // R3 glitch one clock short of the filter length
    pwm = 1'b1;
    for (int k = 1; k <= 12; k++)
      expect_at(k, 10'd1023, 6'h00, 1'b1, 1'b0, 1'b1, "R3 short pulse rejected");
    repeat (G - 1) @(negedge clk);
    pwm = 1'b0;
    repeat (20) @(negedge clk);
    // R3 pulse exactly the filter length passes unchanged
    pwm = 1'b1;
    expect_at(G + 2, 10'd1023, 6'h00, 1'b1, 1'b0, 1'b1, "R3 min pulse before");
    expect_at(G + 3, 10'd1023, 6'h3f, 1'b1, 1'b0, 1'b1, "R3 min pulse start");
    expect_at(2 * G + 2, 10'd1023, 6'h3f, 1'b1, 1'b0, 1'b1, "R3 min pulse end");
    expect_at(2 * G + 3, 10'd1023, 6'h00, 1'b1, 1'b0, 1'b1, "R3 min pulse width");
    repeat (G) @(negedge clk);
    pwm = 1'b0;
    repeat (20) @(negedge clk);

    wait (sb.size() == 0);
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule